// File: doc/BRIEF.md
# I2C Data Hold and Setup Sequencer

This block decides when SDA may change relative to SCL inside an I2C controller, in master or slave role, transmitting or receiving. After a falling SCL edge it holds SCL low through two timed phases. The first is a hold phase that keeps the old SDA level. The second is a setup phase that follows the SDA update. Only after both phases does it release SCL. Both phases count in prescaled ticks. A tick lasts `cfg_presc_i + 1` kernel clock cycles.

When transmitting, the block shifts out a byte, most significant bit first, one bit per falling edge. If the hold phase ends and no byte is pending, SCL stays low until the byte arrives. In slave role with clock stretching turned off, SCL is never pulled low and the setup phase is skipped. Timing and no-stretch settings are latched only while the block is disabled.

Top module: `i2c_hold_setup_seq`

## Requirements
- R1: While `rst_ni` is low or `enable_i` is low, `scl_low_o`, `sda_low_o`, `done_o` and `tx_take_o` stay low, SCL edges are ignored and any partly sent byte is discarded.
- R2: `scl_i` passes through a two-flop synchronizer, so stretching starts on the third rising clock edge after `scl_i` falls. SCL edges seen while a sequence is in progress have no effect.
- R3: After stretching starts, `sda_low_o` keeps its previous value for exactly (HOLD+1)*(PRESC+1) cycles and takes its new value on the next edge.
- R4: With stretching active and data available, `scl_low_o` stays high for exactly (HOLD+SETUP+2)*(PRESC+1) cycles. This is never less than (HOLD+SETUP+1)*(PRESC+1)+1.
- R5: In transmit, `sda_low_o` is the inverse of the data bit (1 pulls SDA low). Bits leave MSB first, and one byte serves eight consecutive falling edges. `tx_take_o` pulses for one cycle when a byte is loaded, and only while `tx_valid_i` is high.
- R6: In transmit with no byte pending when the hold phase ends, SCL stays low and SDA is unchanged for as long as `tx_valid_i` is low. After `tx_valid_i` is seen, the MSB appears on the next edge and SCL is released (SETUP+1)*(PRESC+1) cycles later.
- R7: In receive, SDA is released (`sda_low_o`=0) when the hold phase ends, and the stretch length follows R4.
- R8: In slave role (`role_master_i`=0) with no-stretch latched, `scl_low_o` never goes high, the setup phase is skipped, and `done_o` pulses in the cycle in which SDA takes its new value.
- R9: In master role the no-stretch setting has no effect.
- R10: `cfg_we_i` loads PRESC, HOLD, SETUP and no-stretch only while `enable_i` is low. Writes while enabled are ignored.
- R11: `done_o` is a one-cycle pulse that coincides with the first cycle in which `scl_low_o` is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Kernel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Block enable |
| role_master_i | input | 1 | 1 = master role, 0 = slave role |
| tx_mode_i | input | 1 | 1 = transmit, 0 = receive |
| cfg_we_i | input | 1 | Configuration load strobe |
| cfg_presc_i | input | 4 | Prescaler: tick = value+1 cycles |
| cfg_hold_i | input | 4 | Hold phase length: value+1 ticks |
| cfg_setup_i | input | 4 | Setup phase length: value+1 ticks |
| cfg_nostretch_i | input | 1 | Disable clock stretching (slave only) |
| tx_data_i | input | 8 | Byte to transmit |
| tx_valid_i | input | 1 | Byte on `tx_data_i` is available |
| tx_take_o | output | 1 | Byte accepted this cycle |
| scl_i | input | 1 | SCL bus level (asynchronous) |
| scl_low_o | output | 1 | Pull SCL low |
| sda_low_o | output | 1 | Pull SDA low |
| done_o | output | 1 | Sequence complete, SCL may be released |

## Verification
The bench uses the shortest settings (one tick per phase), where a one-cycle counting error would break the minimum stretch bound, and the longest settings (256 cycles per phase) with an SCL glitch injected mid-hold. A design that restarts on the glitch would stretch too long. It leaves the transmitter with no byte for well past the normal stretch. A design that does not stall would release SCL or drive a stale bit. It also writes new timing while the block is enabled; a design that takes the write would shorten the next phases. It runs slave no-stretch and then master with the same setting. A wrong design would pull SCL low in the first case or skip stretching in the second.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
  localparam int CFG_W = 4;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HOLD,
    ST_WAIT,
    ST_SETUP
  } seq_state_e;
endpackage

// File: rtl/i2c_seq_sync.sv
module i2c_seq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  // bus idles high, so reset to 1 to avoid a false edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      last_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], line_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign fall_o = last_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/i2c_seq_delay.sv
module i2c_seq_delay #(
  parameter int CFG_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             start_i,
  input  logic [CFG_W-1:0] presc_i,
  input  logic [CFG_W-1:0] limit_i,
  output logic             busy_o,
  output logic             done_o
);
  logic [CFG_W-1:0] pcnt_q, tcnt_q;
  logic             run_q;
  logic             last_tick;

  assign last_tick = (pcnt_q == presc_i);
  assign done_o    = run_q && last_tick && (tcnt_q == limit_i);
  assign busy_o    = run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      pcnt_q <= '0;
      tcnt_q <= '0;
    end else if (clear_i) begin
      run_q  <= 1'b0;
      pcnt_q <= '0;
      tcnt_q <= '0;
    end else if (start_i) begin
      run_q  <= 1'b1;
      pcnt_q <= '0;
      tcnt_q <= '0;
    end else if (run_q) begin
      if (last_tick) begin
        pcnt_q <= '0;
        if (tcnt_q == limit_i) run_q <= 1'b0;
        else                   tcnt_q <= tcnt_q + CFG_W'(1);
      end else begin
        pcnt_q <= pcnt_q + CFG_W'(1);
      end
    end
  end

  p_count_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (tcnt_q <= limit_i && pcnt_q <= presc_i));
endmodule

// File: rtl/i2c_hold_setup_seq.sv
module i2c_hold_setup_seq
  import i2c_seq_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              role_master_i,
  input  logic              tx_mode_i,
  input  logic              cfg_we_i,
  input  logic [CFG_W-1:0]  cfg_presc_i,
  input  logic [CFG_W-1:0]  cfg_hold_i,
  input  logic [CFG_W-1:0]  cfg_setup_i,
  input  logic              cfg_nostretch_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_take_o,
  input  logic              scl_i,
  output logic              scl_low_o,
  output logic              sda_low_o,
  output logic              done_o
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic [CFG_W-1:0]  presc_q, hold_q, setup_q;
  logic              ns_q, ns_eff;
  seq_state_e        state_q, state_d;
  logic [CNT_W-1:0]  bits_left_q;
  logic [DATA_W-1:0] shreg_q;
  logic              done_q, done_d;
  logic              scl_fall;
  logic              hold_start, hold_done, hold_busy;
  logic              setup_start, setup_done, setup_busy;
  logic              drive_bit, load_byte, need_byte;

  // configuration latches only while disabled
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      presc_q <= '0;
      hold_q  <= '0;
      setup_q <= '0;
      ns_q    <= 1'b0;
    end else if (cfg_we_i && !enable_i) begin
      presc_q <= cfg_presc_i;
      hold_q  <= cfg_hold_i;
      setup_q <= cfg_setup_i;
      ns_q    <= cfg_nostretch_i;
    end
  end

  assign ns_eff = ns_q & ~role_master_i;

  i2c_seq_sync #(.STAGES(SYNC_STAGES)) i_scl_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .line_i(scl_i),
    .fall_o(scl_fall)
  );

  i2c_seq_delay #(.CFG_W(CFG_W)) i_hold_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(~enable_i),
    .start_i(hold_start),
    .presc_i(presc_q),
    .limit_i(hold_q),
    .busy_o (hold_busy),
    .done_o (hold_done)
  );

  i2c_seq_delay #(.CFG_W(CFG_W)) i_setup_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(~enable_i),
    .start_i(setup_start),
    .presc_i(presc_q),
    .limit_i(setup_q),
    .busy_o (setup_busy),
    .done_o (setup_done)
  );

  assign need_byte = tx_mode_i && (bits_left_q == '0);

  always_comb begin
    state_d     = state_q;
    hold_start  = 1'b0;
    setup_start = 1'b0;
    drive_bit   = 1'b0;
    load_byte   = 1'b0;
    done_d      = 1'b0;
    unique case (state_q)
      ST_IDLE: if (scl_fall) begin
        hold_start = 1'b1;
        state_d    = ST_HOLD;
      end
      ST_HOLD: if (hold_done) begin
        if (need_byte && !tx_valid_i) begin
          state_d = ST_WAIT;
        end else begin
          drive_bit = 1'b1;
          load_byte = need_byte;
        end
      end
      ST_WAIT: if (tx_valid_i) begin
        drive_bit = 1'b1;
        load_byte = 1'b1;
      end
      ST_SETUP: if (setup_done) begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
    // after the SDA update: setup phase, or finish at once without stretch
    if (drive_bit) begin
      if (ns_eff) begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end else begin
        setup_start = 1'b1;
        state_d     = ST_SETUP;
      end
    end
    if (!enable_i) begin
      state_d     = ST_IDLE;
      hold_start  = 1'b0;
      setup_start = 1'b0;
      drive_bit   = 1'b0;
      load_byte   = 1'b0;
      done_d      = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      done_q      <= 1'b0;
      bits_left_q <= '0;
      shreg_q     <= '0;
      sda_low_o   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (!enable_i) begin
        bits_left_q <= '0;
        shreg_q     <= '0;
        sda_low_o   <= 1'b0;
      end else if (drive_bit) begin
        if (!tx_mode_i) begin
          sda_low_o <= 1'b0;
        end else if (load_byte) begin
          sda_low_o   <= ~tx_data_i[DATA_W-1];
          shreg_q     <= {tx_data_i[DATA_W-2:0], 1'b0};
          bits_left_q <= CNT_W'(DATA_W - 1);
        end else begin
          sda_low_o   <= ~shreg_q[DATA_W-1];
          shreg_q     <= {shreg_q[DATA_W-2:0], 1'b0};
          bits_left_q <= bits_left_q - CNT_W'(1);
        end
      end
    end
  end

  assign scl_low_o = (state_q != ST_IDLE) && !ns_eff;
  assign done_o    = done_q;
  assign tx_take_o = load_byte;

  p_sda_hold_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HOLD && !hold_done && enable_i) |=> $stable(sda_low_o));
  p_nostretch_skip_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HOLD && hold_done && ns_eff && enable_i) |=> !setup_busy);
  p_done_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  p_take_valid_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_take_o |-> (tx_valid_i && tx_mode_i));
  p_cfg_locked_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i |=> ($stable(presc_q) && $stable(hold_q) && $stable(setup_q) && $stable(ns_q)));
  p_wait_stall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && !tx_valid_i && enable_i) |=> (state_q == ST_WAIT && $stable(sda_low_o)));
  p_release_done_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(scl_low_o) && enable_i && !ns_eff) |-> done_q);
  p_hold_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HOLD) |-> hold_busy);
endmodule

// File: tb/test_i2c_hold_setup_seq.sv
module test_i2c_hold_setup_seq;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0, role_master = 1'b1, tx_mode = 1'b1;
  logic       cfg_we = 1'b0, cfg_ns = 1'b0;
  logic [3:0] cfg_presc = '0, cfg_hold = '0, cfg_setup = '0;
  logic [7:0] tx_data = '0;
  logic       tx_valid = 1'b0;
  logic       scl = 1'b1;
  logic       tx_take, scl_low, sda_low, done;

  int n_chk = 0, n_err = 0, take_cnt = 0;

  always #(CLK_P/2) clk = ~clk;

  i2c_hold_setup_seq i_i2c_hold_setup_seq (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .role_master_i(role_master),
    .tx_mode_i(tx_mode), .cfg_we_i(cfg_we), .cfg_presc_i(cfg_presc),
    .cfg_hold_i(cfg_hold), .cfg_setup_i(cfg_setup), .cfg_nostretch_i(cfg_ns),
    .tx_data_i(tx_data), .tx_valid_i(tx_valid), .tx_take_o(tx_take),
    .scl_i(scl), .scl_low_o(scl_low), .sda_low_o(sda_low), .done_o(done)
  );

  always begin
    @(negedge clk);
    #1;
    if (tx_take) take_cnt++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic write_cfg(input int p, input int h, input int s, input bit ns);
    @(negedge clk);
    cfg_presc = 4'(p); cfg_hold = 4'(h); cfg_setup = 4'(s); cfg_ns = ns; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic scl_idle();
    scl = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // one falling edge; counts n from the negedge where scl drops
  task automatic run_bit(input bit stretch, input int lh, input int ls, input bit sda_prev,
                         input bit sda_exp, input int glitch, input string tag);
    int total = stretch ? 3 + lh + ls : 3 + lh;
    int bad_scl = -1, bad_sda = -1, bad_done = -1;
    bit e_scl, e_sda, e_done;
    @(negedge clk);
    scl = 1'b0;
    for (int n = 1; n <= total + 2; n++) begin
      @(negedge clk);
      if (glitch != 0 && n == glitch)     scl = 1'b1;
      if (glitch != 0 && n == glitch + 4) scl = 1'b0;
      e_scl  = stretch && n >= 3 && n < total;
      e_sda  = (n < 3 + lh) ? sda_prev : sda_exp;
      e_done = (n == total);
      if (scl_low != e_scl && bad_scl < 0)  bad_scl = n;
      if (sda_low != e_sda && bad_sda < 0)  bad_sda = n;
      if (done != e_done && bad_done < 0)   bad_done = n;
    end
    chk(bad_scl < 0, {tag, " R2/R4 scl_low timing (first bad cycle)"}, bad_scl, -1);
    chk(bad_sda < 0, {tag, " R3 sda_low timing/value (first bad cycle)"}, bad_sda, -1);
    chk(bad_done < 0, {tag, " R11 done pulse (first bad cycle)"}, bad_done, -1);
    scl_idle();
  endtask

  task automatic t_reset();
    chk(scl_low == 0 && sda_low == 0 && done == 0 && tx_take == 0, "R1 reset outputs",
        {scl_low, sda_low, done, tx_take}, 0);
  endtask

  task automatic t_tx_byte();
    logic [7:0] b = 8'hA5;
    bit prev = 1'b0;
    write_cfg(2, 3, 1, 1'b0);
    enable = 1'b1; role_master = 1'b1; tx_mode = 1'b1;
    tx_data = b; tx_valid = 1'b1;
    scl_idle();
    for (int i = 7; i >= 0; i--) begin
      run_bit(1'b1, 12, 6, prev, ~b[i], 0, "R5 tx A5 bit");
      prev = ~b[i];
      tx_valid = 1'b0;
    end
    chk(take_cnt == 1, "R5 one take per byte", take_cnt, 1);
  endtask

  task automatic t_wait();
    int bad = -1;
    tx_valid = 1'b0;
    @(negedge clk);
    scl = 1'b0;
    for (int n = 1; n <= 3 + 12 + 6 + 20; n++) begin
      @(negedge clk);
      if ((n >= 3 && !scl_low) || sda_low != 1'b0 || done) if (bad < 0) bad = n;
    end
    chk(bad < 0, "R6 stall without byte (first bad cycle)", bad, -1);
    tx_data = 8'h3C; tx_valid = 1'b1;
    bad = -1;
    for (int m = 1; m <= 6 + 3; m++) begin
      @(negedge clk);
      if (m == 1) chk(sda_low == 1'b1, "R6 MSB after byte arrives", sda_low, 1);
      if (scl_low != (m < 7) || done != (m == 7)) if (bad < 0) bad = m;
    end
    chk(bad < 0, "R6 setup after stall (first bad cycle)", bad, -1);
    tx_valid = 1'b0;
    chk(take_cnt == 2, "R6 byte taken from stall", take_cnt, 2);
    scl_idle();
  endtask

  task automatic t_cfg_locked();
    write_cfg(0, 0, 0, 1'b1);
    // 0x3C bit6 = 0: sda stays pulled low; old timing must still apply
    run_bit(1'b1, 12, 6, 1'b1, 1'b1, 0, "R10 write while enabled ignored");
  endtask

  task automatic t_nostretch();
    int bad = -1;
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    scl = 1'b0;
    for (int n = 1; n <= 6; n++) begin
      @(negedge clk);
      if (scl_low || done || sda_low) if (bad < 0) bad = n;
    end
    chk(bad < 0, "R1 disabled ignores SCL and clears SDA", bad, -1);
    scl_idle();
    write_cfg(0, 0, 0, 1'b1);
    enable = 1'b1; role_master = 1'b0; tx_mode = 1'b1;
    tx_data = 8'h5A; tx_valid = 1'b1;
    scl_idle();
    run_bit(1'b0, 1, 1, 1'b0, 1'b1, 0, "R8 slave no-stretch");
    tx_valid = 1'b0;
    chk(take_cnt == 3, "R8 byte taken without stretch", take_cnt, 3);
  endtask

  task automatic t_master_rx();
    role_master = 1'b1; tx_mode = 1'b0;
    run_bit(1'b1, 1, 1, 1'b1, 1'b0, 0, "R7/R9 master rx with no-stretch latched");
    chk(take_cnt == 3, "R7 no take in receive", take_cnt, 3);
  endtask

  task automatic t_long_glitch();
    @(negedge clk);
    enable = 1'b0;
    write_cfg(15, 15, 15, 1'b0);
    enable = 1'b1; role_master = 1'b1; tx_mode = 1'b0;
    scl_idle();
    run_bit(1'b1, 256, 256, 1'b0, 1'b0, 40, "R2 glitch ignored, max delays");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_tx_byte();
    t_wait();
    t_cfg_locked();
    t_nostretch();
    t_master_rx();
    t_long_glitch();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule